// File: doc/BRIEF.md
# Dual-Channel IDE Card Interrupt Glue

This block is the register-side glue on a two-channel parallel ATA expansion card. A byte-wide host bus reaches it with a 14-bit address, a write strobe and a read strobe. Read data is returned in the same cycle as the read strobe. Each ATA channel gives the block a level interrupt line. The block gates each line with a per-channel enable and drives one registered card interrupt.

Each channel's enable has an unusual handshake. Any write to the channel's mask location sets the enable. Reading that same location clears it. A status location per channel returns the raw level of the drive line. A select register has two jobs: it opens the extended address window through which the taskfile is reached, and it steers the card's single DMA path to one channel. A 4-bit board code is spread as single bits over four addresses four bytes apart. The block also decodes each channel's taskfile registers and control register into select strobes and a register index. These strobes are active only while the extended window is open.

Top module: `dual_ide_irq_glue`

## Requirements
- R1: Writing any data byte to a channel's mask location sets that channel's interrupt enable on the next clock edge. The mask location is 0x2200 for channel 1 and 0x3200 for channel 2.
- R2: Reading a channel's mask location clears that channel's enable on the next clock edge, and the read returns 0x00.
- R3: Reading 0x2290 (channel 1) or 0x3290 (channel 2) returns the current level of that channel's drive interrupt line in bit 0, with bits 7..1 at 0. The level is not latched and does not depend on the enable.
- R4: card_irq is registered. It equals the OR over both channels of (drive line AND enable) as sampled at the previous clock edge.
- R5: Writes to 0x0000 load the select register. Bit 0 drives dma_ch2 (1 = channel 2, 0 = channel 1), and bit 5 drives ext_win_en. Writing 0x00 clears both outputs.
- R6: Reads of 0x2280, 0x2284, 0x2288 and 0x228C return, in bit 0, board code bits 0, 1, 2 and 3 respectively. The default code is 3, so these reads give 1, 1, 0, 0.
- R7: While ext_win_en is 1, an address equal to the channel's data base plus (n << 6), for n from 0 to 7, raises tf_sel for that channel (bit 0 = channel 1, bit 1 = channel 2) and presents n on tf_reg. The data base is 0x2000 for channel 1 and 0x3000 for channel 2. Any other address leaves tf_sel at 0 and tf_reg at 0.
- R8: While ext_win_en is 1, address 0x2380 raises ctl_sel bit 0 and address 0x3380 raises ctl_sel bit 1.
- R9: While ext_win_en is 0, tf_sel and ctl_sel stay 0 for every address.
- R10: After reset, both enables are clear, the select register is 0 and card_irq is 0.
- R11: A read of any address not named above, and bus_rdata whenever no read is active, return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 14 | Host byte address |
| bus_wdata | input | 8 | Host write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid in the cycle of bus_rd |
| drv_irq | input | 2 | Drive interrupt line per channel, active high |
| card_irq | output | 1 | Combined registered card interrupt |
| dma_ch2 | output | 1 | DMA routing: 1 = channel 2 |
| ext_win_en | output | 1 | Extended window open |
| tf_sel | output | 2 | Taskfile register select per channel |
| tf_reg | output | 3 | Taskfile register index |
| ctl_sel | output | 2 | Control register select per channel |

## Verification
The interrupt path is driven with the drive lines pending both with and without enables. Each channel is enabled alone and then disabled by a read, which shows whether the enable set and clear reach the right channel, and whether card_irq takes exactly one cycle. Status reads are taken with the enables off and after a line falls; these separate a raw, unlatched level from a gated or held one. A table of addresses covering the first, middle and last taskfile slot of each channel, the control registers, misaligned addresses and neighbouring registers is walked with the window open and then closed. This shows both the decode and its gating by the select register.

// File: rtl/dig_pkg.sv
package dig_pkg;
  localparam int ADDR_W    = 14;
  localparam int DATA_W    = 8;
  localparam int NCH       = 2;
  localparam int ID_BITS   = 4;
  localparam int TF_STEP   = 6;
  localparam int TF_REGS   = 8;
  localparam int TF_IDX_W  = $clog2(TF_REGS);
  localparam int CH_STRIDE = 'h1000;
  localparam int SEL_DMA_BIT = 0;
  localparam int SEL_WIN_BIT = 5;

  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t SEL_ADDR = addr_t'(0);

  function automatic addr_t mask_addr(int ch);
    return addr_t'(32'h2200 + ch * CH_STRIDE);
  endfunction

  function automatic addr_t stat_addr(int ch);
    return addr_t'(32'h2290 + ch * CH_STRIDE);
  endfunction

  function automatic addr_t data_base(int ch);
    return addr_t'(32'h2000 + ch * CH_STRIDE);
  endfunction

  function automatic addr_t ctl_addr(int ch);
    return addr_t'(32'h2380 + ch * CH_STRIDE);
  endfunction

  function automatic addr_t id_addr(int bitno);
    return addr_t'(32'h2280 + bitno * 4);
  endfunction

  function automatic logic tf_in_window(addr_t a, int ch);
    addr_t span;
    addr_t align;
    span  = addr_t'((TF_REGS << TF_STEP) - 1);
    align = addr_t'((1 << TF_STEP) - 1);
    return ((a & ~span) == data_base(ch)) && ((a & align) == '0);
  endfunction

  function automatic logic [TF_IDX_W-1:0] tf_index(addr_t a);
    return a[TF_STEP +: TF_IDX_W];
  endfunction
endpackage

// File: rtl/dig_addr_dec.sv
module dig_addr_dec
  import dig_pkg::*;
(
  input  addr_t                addr,
  input  logic                 win_en,
  output logic [NCH-1:0]       mask_hit,
  output logic [NCH-1:0]       stat_hit,
  output logic [ID_BITS-1:0]   id_hit,
  output logic                 sel_hit,
  output logic [NCH-1:0]       tf_sel,
  output logic [TF_IDX_W-1:0]  tf_idx,
  output logic [NCH-1:0]       ctl_sel
);
  assign sel_hit = (addr == SEL_ADDR);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    assign mask_hit[ch] = (addr == mask_addr(ch));
    assign stat_hit[ch] = (addr == stat_addr(ch));
    assign tf_sel[ch]   = win_en && tf_in_window(addr, ch);
    assign ctl_sel[ch]  = win_en && (addr == ctl_addr(ch));
  end

  for (genvar b = 0; b < ID_BITS; b++) begin : g_id
    assign id_hit[b] = (addr == id_addr(b));
  end

  assign tf_idx = (|tf_sel) ? tf_index(addr) : '0;
endmodule

// File: rtl/dig_chan_irq.sv
module dig_chan_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_en,
  input  logic clr_en,
  input  logic line,
  output logic en,
  output logic req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en <= 1'b0;
    else if (set_en) en <= 1'b1;
    else if (clr_en) en <= 1'b0;
  end

  assign req = line && en;
endmodule

// File: rtl/dig_sel_reg.sv
module dig_sel_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic dma_bit,
  input  logic win_bit,
  output logic dma_ch2,
  output logic win_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_ch2 <= 1'b0;
      win_en  <= 1'b0;
    end else if (we) begin
      dma_ch2 <= dma_bit;
      win_en  <= win_bit;
    end
  end
endmodule

// File: rtl/dual_ide_irq_glue.sv
module dual_ide_irq_glue
  import dig_pkg::*;
#(
  parameter logic [ID_BITS-1:0] BOARD_ID = 4'd3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NCH-1:0]       drv_irq,
  output logic                 card_irq,
  output logic                 dma_ch2,
  output logic                 ext_win_en,
  output logic [NCH-1:0]       tf_sel,
  output logic [TF_IDX_W-1:0]  tf_reg,
  output logic [NCH-1:0]       ctl_sel
);
  logic [NCH-1:0]     mask_hit;
  logic [NCH-1:0]     stat_hit;
  logic [ID_BITS-1:0] id_hit;
  logic               sel_hit;
  logic [NCH-1:0]     chan_en;
  logic [NCH-1:0]     chan_req;
  logic [DATA_W-1:0]  rd_mux;
  logic               unused_wdata;

  assign unused_wdata = ^bus_wdata;

  dig_addr_dec u_dec (
    .addr     (bus_addr),
    .win_en   (ext_win_en),
    .mask_hit (mask_hit),
    .stat_hit (stat_hit),
    .id_hit   (id_hit),
    .sel_hit  (sel_hit),
    .tf_sel   (tf_sel),
    .tf_idx   (tf_reg),
    .ctl_sel  (ctl_sel)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_irq
    dig_chan_irq u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (bus_wr && mask_hit[ch]),
      .clr_en (bus_rd && mask_hit[ch]),
      .line   (drv_irq[ch]),
      .en     (chan_en[ch]),
      .req    (chan_req[ch])
    );
  end

  dig_sel_reg u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bus_wr && sel_hit),
    .dma_bit (bus_wdata[SEL_DMA_BIT]),
    .win_bit (bus_wdata[SEL_WIN_BIT]),
    .dma_ch2 (dma_ch2),
    .win_en  (ext_win_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) card_irq <= 1'b0;
    else        card_irq <= |chan_req;
  end

  always_comb begin
    rd_mux = '0;
    for (int ch = 0; ch < NCH; ch++)
      if (stat_hit[ch]) rd_mux[0] = drv_irq[ch];
    for (int b = 0; b < ID_BITS; b++)
      if (id_hit[b]) rd_mux[0] = BOARD_ID[b];
  end

  assign bus_rdata = bus_rd ? rd_mux : '0;
endmodule

// File: rtl/dig_glue_chk.sv
module dig_glue_chk
  import dig_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NCH-1:0]      drv_irq,
  input logic                card_irq,
  input logic                dma_ch2,
  input logic                ext_win_en,
  input logic [NCH-1:0]      tf_sel,
  input logic [NCH-1:0]      ctl_sel,
  input logic [NCH-1:0]      chan_en
);
  a_r1_write_sets_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == mask_addr(0)) |=> chan_en[0]);
  a_r1_write_sets_ch2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == mask_addr(1)) |=> chan_en[1]);
  a_r2_read_clears_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == mask_addr(0)) |=> !chan_en[0]);
  a_r2_read_clears_ch2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == mask_addr(1)) |=> !chan_en[1]);
  a_r3_status_level: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == stat_addr(1)) |-> bus_rdata == {7'd0, drv_irq[1]});
  a_r4_irq_latency: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> card_irq == $past(|(drv_irq & chan_en)));
  a_r5_dma_route: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == SEL_ADDR) |=> dma_ch2 == $past(bus_wdata[SEL_DMA_BIT]));
  a_r7_tf_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tf_sel));
  a_r9_window_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_win_en |-> (tf_sel == '0 && ctl_sel == '0));
  a_r11_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);
endmodule

bind dual_ide_irq_glue dig_glue_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .drv_irq    (drv_irq),
  .card_irq   (card_irq),
  .dma_ch2    (dma_ch2),
  .ext_win_en (ext_win_en),
  .tf_sel     (tf_sel),
  .ctl_sel    (ctl_sel),
  .chan_en    (chan_en)
);

// File: tb/dual_ide_irq_glue_tb.sv
module dual_ide_irq_glue_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [1:0]  drv_irq = '0;
  logic        card_irq;
  logic        dma_ch2;
  logic        ext_win_en;
  logic [1:0]  tf_sel;
  logic [2:0]  tf_reg;
  logic [1:0]  ctl_sel;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_ide_irq_glue u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .drv_irq(drv_irq), .card_irq(card_irq), .dma_ch2(dma_ch2),
    .ext_win_en(ext_win_en), .tf_sel(tf_sel), .tf_reg(tf_reg), .ctl_sel(ctl_sel)
  );

  // Entry: {addr[13:0], tf_sel[1:0], tf_reg[2:0], ctl_sel[1:0]} with window open
  localparam int NV = 12;
  localparam logic [20:0] VEC [NV] = '{
    {14'h2000, 2'b01, 3'd0, 2'b00},
    {14'h2040, 2'b01, 3'd1, 2'b00},
    {14'h21C0, 2'b01, 3'd7, 2'b00},
    {14'h3000, 2'b10, 3'd0, 2'b00},
    {14'h3080, 2'b10, 3'd2, 2'b00},
    {14'h31C0, 2'b10, 3'd7, 2'b00},
    {14'h2380, 2'b00, 3'd0, 2'b01},
    {14'h3380, 2'b00, 3'd0, 2'b10},
    {14'h2200, 2'b00, 3'd0, 2'b00},
    {14'h2010, 2'b00, 3'd0, 2'b00},
    {14'h2290, 2'b00, 3'd0, 2'b00},
    {14'h1000, 2'b00, 3'd0, 2'b00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [13:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [13:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    bus_addr = 14'h2000;
    #1;
    // R10 reset state
    chk("R10 card_irq", card_irq, 0);
    chk("R10 dma_ch2", dma_ch2, 0);
    chk("R10 ext_win_en", ext_win_en, 0);
    chk("R9 tf_sel window closed", tf_sel, 0);
    chk("R11 idle rdata", bus_rdata, 0);
    drv_irq = 2'b11;
    repeat (2) @(negedge clk);
    chk("R10 enables clear", card_irq, 0);

    // R3 raw status with enables off
    do_rd(14'h2290, rd); chk("R3 ch1 status", rd, 8'h01);
    do_rd(14'h3290, rd); chk("R3 ch2 status", rd, 8'h01);
    drv_irq = 2'b01;
    do_rd(14'h3290, rd); chk("R3 ch2 low", rd, 8'h00);

    // R6 board code bits
    do_rd(14'h2280, rd); chk("R6 id bit0", rd, 8'h01);
    do_rd(14'h2284, rd); chk("R6 id bit1", rd, 8'h01);
    do_rd(14'h2288, rd); chk("R6 id bit2", rd, 8'h00);
    do_rd(14'h228C, rd); chk("R6 id bit3", rd, 8'h00);
    do_rd(14'h1234, rd); chk("R11 unmapped read", rd, 8'h00);

    // R1 / R4 enable per channel
    drv_irq = 2'b10;
    do_wr(14'h2200, 8'hA5);
    @(negedge clk);
    chk("R1 ch1 enable, ch1 idle", card_irq, 0);
    do_wr(14'h3200, 8'h00);
    chk("R4 one-cycle latency", card_irq, 0);
    @(negedge clk);
    chk("R1 ch2 enabled by zero write", card_irq, 1);

    // R2 read disables
    do_rd(14'h3200, rd);
    chk("R2 mask read data", rd, 8'h00);
    @(negedge clk);
    chk("R2 ch2 disabled", card_irq, 0);

    // R4 ch1 still enabled, follows line
    drv_irq = 2'b01;
    @(negedge clk);
    chk("R4 ch1 pending", card_irq, 1);
    drv_irq = 2'b00;
    @(negedge clk);
    chk("R4 ch1 falls", card_irq, 0);
    do_rd(14'h2290, rd); chk("R3 not latched", rd, 8'h00);

    // R5 select register
    do_wr(14'h0000, 8'h21);
    chk("R5 dma_ch2 set", dma_ch2, 1);
    chk("R5 window open", ext_win_en, 1);

    // R7 / R8 decode table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_addr = VEC[i][20:7];
      #1;
      chk($sformatf("R7 tf_sel @%h", VEC[i][20:7]), tf_sel, VEC[i][6:5]);
      chk($sformatf("R7 tf_reg @%h", VEC[i][20:7]), tf_reg, VEC[i][4:2]);
      chk($sformatf("R8 ctl_sel @%h", VEC[i][20:7]), ctl_sel, VEC[i][1:0]);
    end

    do_wr(14'h0000, 8'h20);
    chk("R5 dma to ch1", dma_ch2, 0);
    do_wr(14'h0000, 8'h00);
    chk("R5 zero closes window", ext_win_en, 0);
    bus_addr = 14'h3000; #1;
    chk("R9 tf closed", tf_sel, 0);
    bus_addr = 14'h3380; #1;
    chk("R9 ctl closed", ctl_sel, 0);

    // R10 reset mid-run
    do_wr(14'h0000, 8'h21);
    do_wr(14'h3200, 8'h01);
    drv_irq = 2'b10;
    @(negedge clk);
    chk("R4 before reset", card_irq, 1);
    rst_n = 1'b0; #1;
    chk("R10 irq cleared", card_irq, 0);
    chk("R10 select cleared", dma_ch2, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 enable cleared", card_irq, 0);

    done = 1'b1;
    summary();
  end
endmodule